// File: doc/BRIEF.md
# Multi-channel ADC sequence controller

This block is a register-mapped controller that walks an eight-input analog-to-digital converter through a programmed list of conversions and keeps each result in its own 16-bit result register. Software enables the block, chooses how many conversions make up a sequence, picks 8-bit or 10-bit results and their justification, and chooses between stepping through channels or converting one channel over and over. A write to the start register launches the sequence. When every conversion in it has been stored, a sequence-complete flag rises. In continuous mode the next sequence follows at once.

The converter itself sits outside the block. It is reached through two valid/ready streams. On the request stream the controller holds `req_valid` and `req_chan` steady until the converter raises `req_ready`, and it sends only one request at a time. On the response stream `rsp_ready` is high only while a conversion is outstanding. The converter keeps `rsp_valid` and `rsp_data` steady until they are taken, and a response offered while `rsp_ready` is low is not stored. The register port is a plain single-cycle bus, and `reg_rdata` follows `reg_addr` combinationally.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While the enable bit (bit 7 at address 0x02) is 0, no conversion request is issued, and a start write launches nothing.
- R2: A request keeps `req_valid` high and `req_chan` unchanged until `req_ready` is seen. Only one conversion is outstanding at a time, and a response is taken only while `rsp_ready` is high.
- R3: The 4-bit length field (bits 3:0 at 0x03) gives the number of conversions in a sequence. A value v from 0 to 7 gives v+1 conversions, and any value with bit 3 set gives eight.
- R4: At the start register (0x05), bits 2:0 give the first channel. With bit 4 = 1 the k-th conversion uses channel (first+k) mod 8. With bit 4 = 0 every conversion uses the first channel. Conversion k is stored in result slot k, with its high byte at 0x10+2k and its low byte at 0x11+2k.
- R5: The sequence-complete flag (bit 7 at 0x06) rises after the last conversion of a sequence is stored, and not before.
- R6: A write to the start register clears the flag. Writing 1 to bit 7 at 0x06 clears it, and writing 0 there leaves it unchanged.
- R7: When the fast-clear bit (bit 6 at 0x02) is 1, a read of any result byte clears the flag. When that bit is 0, such a read leaves the flag unchanged.
- R8: The result format is set by bit 7 at 0x04 (1 = 8 bits, keeping the top 8 bits of the 10-bit sample) and by bit 7 of the start register (1 = left-justified, bit 15 aligned, unused low bits zero; 0 = right-justified, high unused bits zero).
- R9: The per-slot bitmap at 0x0B is cleared by a start write. Bit k sets when slot k is stored, and the first store of a new continuous pass clears the other bits.
- R10: With bit 5 of the start register = 1, a new sequence begins right after the last store, and the flag is set again at the end of each sequence without another start write.
- R11: Address 0x0F reads the pin levels ANDed with the digital-enable mask at 0x0D.
- R12: After reset every register reads zero. Addresses outside 0x02–0x06, 0x0B, 0x0D, 0x0F and 0x10–0x1F read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| pin_in | input | 8 | Digital levels of the eight input pins |
| req_valid | output | 1 | Conversion request valid |
| req_ready | input | 1 | Converter accepts request |
| req_chan | output | 3 | Channel to convert |
| rsp_valid | input | 1 | Conversion result valid |
| rsp_ready | output | 1 | Controller waits for a result |
| rsp_data | input | 10 | Raw conversion result |

## Verification
The bench goes after the length encoding at its saturation point (a value with bit 3 set). A design that decodes only the low three bits would run too few conversions, and the count of requests shows it. A start channel near the top is used so that the channel index must wrap. A missing wrap sends requests to channels beyond 7 or in the wrong order. Each of the three flag-clearing paths is exercised along with its non-clearing counterpart (writing 0, and a read with fast-clear off), so a flag that clears too eagerly or never is caught. Continuous mode must set the flag again with no new start write, and disabling must stop the request stream, which would otherwise keep running.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NUM_CH = 8;
  localparam int CH_W   = 3;
  localparam int LEN_W  = CH_W + 1;
  localparam int RAW_W  = 10;
  localparam int RES_W  = 16;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADR_PWR  = 5'h02;
  localparam logic [ADDR_W-1:0] ADR_LEN  = 5'h03;
  localparam logic [ADDR_W-1:0] ADR_FMT  = 5'h04;
  localparam logic [ADDR_W-1:0] ADR_GO   = 5'h05;
  localparam logic [ADDR_W-1:0] ADR_SEQ  = 5'h06;
  localparam logic [ADDR_W-1:0] ADR_MAP  = 5'h0B;
  localparam logic [ADDR_W-1:0] ADR_DEN  = 5'h0D;
  localparam logic [ADDR_W-1:0] ADR_PORT = 5'h0F;
  localparam logic [ADDR_W-1:0] ADR_RES  = 5'h10;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} seq_state_t;

  typedef struct packed {
    logic             pwr;
    logic             fast_clr;
    logic [LEN_W-1:0] len;
    logic             res8;
    logic             left;
    logic             cont;
    logic             multi;
    logic [CH_W-1:0]  first_ch;
  } seq_cfg_t;
endpackage

// File: rtl/adc_seq_fmt.sv
module adc_seq_fmt
  import adc_seq_pkg::*;
#(
  parameter int RAW_BITS = RAW_W,
  parameter int WORD_W   = RES_W,
  parameter int NARROW_W = 8
) (
  input  logic [RAW_BITS-1:0] raw,
  input  logic                res8,
  input  logic                left,
  output logic [WORD_W-1:0]   word
);
  localparam int PAD_N = WORD_W - NARROW_W;
  localparam int PAD_W = WORD_W - RAW_BITS;

  logic [NARROW_W-1:0] narrow;
  assign narrow = raw[RAW_BITS-1 -: NARROW_W];

  always_comb begin
    unique case ({res8, left})
      2'b11:   word = {narrow, {PAD_N{1'b0}}};
      2'b10:   word = {{PAD_N{1'b0}}, narrow};
      2'b01:   word = {raw, {PAD_W{1'b0}}};
      default: word = {{PAD_W{1'b0}}, raw};
    endcase
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CHANNELS = NUM_CH,
  parameter int IDX_W    = CH_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             pwr,
  input  logic [IDX_W:0]   len,
  input  logic             multi,
  input  logic             cont,
  input  logic [IDX_W-1:0] first_ch,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [IDX_W-1:0] req_chan,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  output logic             store,
  output logic [IDX_W-1:0] slot,
  output logic             seq_done
);
  seq_state_t       state_q;
  logic [IDX_W-1:0] k_q;
  logic [IDX_W-1:0] last_idx;
  logic [IDX_W:0]   sum;

  // saturating length decode
  always_comb begin
    if (len[IDX_W] || (int'(len[IDX_W-1:0]) >= CHANNELS))
      last_idx = IDX_W'(CHANNELS - 1);
    else
      last_idx = len[IDX_W-1:0];
  end

  // channel for the current step, wrapping past the top channel
  always_comb begin
    sum = {1'b0, first_ch} + {1'b0, k_q};
    if (int'(sum) >= CHANNELS) sum = sum - (IDX_W + 1)'(CHANNELS);
  end

  assign req_chan  = multi ? sum[IDX_W-1:0] : first_ch;
  assign req_valid = (state_q == S_REQ);
  assign rsp_ready = (state_q == S_WAIT) && pwr;
  assign store     = rsp_ready && rsp_valid;
  assign slot      = k_q;
  assign seq_done  = store && (k_q == last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      k_q     <= '0;
    end else if (go) begin
      state_q <= S_REQ;
      k_q     <= '0;
    end else if (!pwr) begin
      state_q <= S_IDLE;
      k_q     <= '0;
    end else begin
      unique case (state_q)
        S_REQ:  if (req_ready) state_q <= S_WAIT;
        S_WAIT: if (rsp_valid) begin
          if (k_q == last_idx) begin
            k_q     <= '0;
            state_q <= cont ? S_REQ : S_IDLE;
          end else begin
            k_q     <= k_q + 1'b1;
            state_q <= S_REQ;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int CHANNELS = NUM_CH,
  parameter int IDX_W    = CH_W,
  parameter int WORD_W   = RES_W,
  parameter int A_W      = ADDR_W,
  parameter int D_W      = DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [A_W-1:0]      bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [D_W-1:0]      bus_wdata,
  output logic [D_W-1:0]      bus_rdata,
  input  logic [D_W-1:0]      pin_in,
  input  logic                store,
  input  logic [IDX_W-1:0]    store_slot,
  input  logic [WORD_W-1:0]   store_word,
  input  logic                seq_done,
  output seq_cfg_t            cfg,
  output logic                go,
  output logic                flag,
  output logic [CHANNELS-1:0] chan_map
);
  localparam int RES_BYTES = 2 * CHANNELS;

  seq_cfg_t          cfg_q;
  logic [D_W-1:0]    den_q;
  logic              flag_q;
  logic [CHANNELS-1:0] map_q;
  logic [WORD_W-1:0] res_q [CHANNELS];

  logic wr_pwr, wr_len, wr_fmt, wr_go, wr_seq, wr_den;
  logic [A_W-1:0]   res_off;
  logic             res_hit;
  logic [IDX_W-1:0] res_idx;
  logic             fast_rd;
  logic [WORD_W-1:0] sel_word;

  assign wr_pwr = bus_wr && (bus_addr == ADR_PWR);
  assign wr_len = bus_wr && (bus_addr == ADR_LEN);
  assign wr_fmt = bus_wr && (bus_addr == ADR_FMT);
  assign wr_go  = bus_wr && (bus_addr == ADR_GO);
  assign wr_seq = bus_wr && (bus_addr == ADR_SEQ);
  assign wr_den = bus_wr && (bus_addr == ADR_DEN);

  assign res_off = bus_addr - ADR_RES;
  assign res_hit = (bus_addr >= ADR_RES) && (int'(res_off) < RES_BYTES);
  assign res_idx = res_off[IDX_W:1];
  assign fast_rd = bus_rd && res_hit && cfg_q.fast_clr;
  assign go      = wr_go && cfg_q.pwr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      den_q <= '0;
    end else begin
      if (wr_pwr) begin
        cfg_q.pwr      <= bus_wdata[7];
        cfg_q.fast_clr <= bus_wdata[6];
      end
      if (wr_len) cfg_q.len  <= bus_wdata[IDX_W:0];
      if (wr_fmt) cfg_q.res8 <= bus_wdata[7];
      if (wr_go) begin
        cfg_q.left     <= bus_wdata[7];
        cfg_q.cont     <= bus_wdata[5];
        cfg_q.multi    <= bus_wdata[4];
        cfg_q.first_ch <= bus_wdata[IDX_W-1:0];
      end
      if (wr_den) den_q <= bus_wdata;
    end
  end

  // completion flag: start write wins, then completion, then clears
  always_ff @(posedge clk) begin
    if (!rst_n)                                flag_q <= 1'b0;
    else if (wr_go)                            flag_q <= 1'b0;
    else if (seq_done)                         flag_q <= 1'b1;
    else if ((wr_seq && bus_wdata[7]) || fast_rd) flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     map_q <= '0;
    else if (go)    map_q <= '0;
    else if (store) map_q <= ((store_slot == '0) ? '0 : map_q) | (CHANNELS'(1) << store_slot);
  end

  for (genvar c = 0; c < CHANNELS; c++) begin : g_res
    always_ff @(posedge clk) begin
      if (!rst_n) res_q[c] <= '0;
      else if (store && (store_slot == IDX_W'(c))) res_q[c] <= store_word;
    end
  end

  assign sel_word = res_q[res_idx];

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADR_PWR:  begin bus_rdata[7] = cfg_q.pwr; bus_rdata[6] = cfg_q.fast_clr; end
      ADR_LEN:  bus_rdata[IDX_W:0] = cfg_q.len;
      ADR_FMT:  bus_rdata[7] = cfg_q.res8;
      ADR_GO:   begin
        bus_rdata[7] = cfg_q.left;
        bus_rdata[5] = cfg_q.cont;
        bus_rdata[4] = cfg_q.multi;
        bus_rdata[IDX_W-1:0] = cfg_q.first_ch;
      end
      ADR_SEQ:  bus_rdata[7] = flag_q;
      ADR_MAP:  bus_rdata[CHANNELS-1:0] = map_q;
      ADR_DEN:  bus_rdata = den_q;
      ADR_PORT: bus_rdata = pin_in & den_q;
      default:  if (res_hit)
        bus_rdata = res_off[0] ? sel_word[D_W-1:0] : sel_word[WORD_W-1 -: D_W];
    endcase
  end

  assign cfg      = cfg_q;
  assign flag     = flag_q;
  assign chan_map = map_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CHANNELS = NUM_CH,
  parameter int RAW_BITS = RAW_W,
  parameter int WORD_W   = RES_W,
  parameter int A_W      = ADDR_W,
  parameter int D_W      = DATA_W,
  localparam int IDX_W   = $clog2(CHANNELS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [A_W-1:0]   reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [D_W-1:0]   reg_wdata,
  output logic [D_W-1:0]   reg_rdata,
  input  logic [D_W-1:0]   pin_in,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [IDX_W-1:0] req_chan,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [RAW_BITS-1:0] rsp_data
);
  seq_cfg_t            cfg;
  logic                go, store, seq_done, seq_flag;
  logic [IDX_W-1:0]    slot;
  logic [WORD_W-1:0]   word;
  logic [CHANNELS-1:0] chan_map;

  adc_seq_regs #(
    .CHANNELS(CHANNELS), .IDX_W(IDX_W), .WORD_W(WORD_W), .A_W(A_W), .D_W(D_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(reg_addr), .bus_wr(reg_wr), .bus_rd(reg_rd),
    .bus_wdata(reg_wdata), .bus_rdata(reg_rdata), .pin_in(pin_in),
    .store(store), .store_slot(slot), .store_word(word), .seq_done(seq_done),
    .cfg(cfg), .go(go), .flag(seq_flag), .chan_map(chan_map)
  );

  adc_seq_fsm #(.CHANNELS(CHANNELS), .IDX_W(IDX_W)) fsm_i (
    .clk(clk), .rst_n(rst_n), .go(go), .pwr(cfg.pwr),
    .len(cfg.len), .multi(cfg.multi), .cont(cfg.cont), .first_ch(cfg.first_ch),
    .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .store(store), .slot(slot), .seq_done(seq_done)
  );

  adc_seq_fmt #(.RAW_BITS(RAW_BITS), .WORD_W(WORD_W)) fmt_i (
    .raw(rsp_data), .res8(cfg.res8), .left(cfg.left), .word(word)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
  import adc_seq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              req_valid,
  input logic              req_ready,
  input logic [CH_W-1:0]   req_chan,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              pwr,
  input logic              flag,
  input logic [NUM_CH-1:0] chan_map
);
  // R1
  pwr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr |=> !req_valid);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && pwr && !(bus_wr && bus_addr == ADR_GO))
    |=> (req_valid && $stable(req_chan)));

  // R2
  one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready));

  // R5
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(rsp_valid && rsp_ready));

  // R6
  go_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADR_GO) |=> !flag);

  // R6
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADR_SEQ && bus_wdata[7] && !(rsp_valid && rsp_ready)) |=> !flag);

  // R9
  map_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADR_GO && pwr) |=> (chan_map == '0));
endmodule

bind adc_seq_ctrl adc_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(reg_addr), .bus_wr(reg_wr), .bus_wdata(reg_wdata),
  .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .pwr(cfg.pwr), .flag(seq_flag), .chan_map(chan_map)
);

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
  import adc_seq_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata, pin_in = '0;
  logic       req_valid, req_ready = 1'b0, rsp_valid = 1'b0, rsp_ready;
  logic [2:0] req_chan;
  logic [9:0] rsp_data = '0;

  int n_chk = 0, n_fail = 0;
  bit done_rep = 0;

  // converter model state
  int busy = 0, cnt = 0, nreq = 0, ptr = 0, conv_n = 0;
  logic [2:0] chan_log [64];
  logic [9:0] data_log [64];
  logic [2:0] cur_ch = '0;

  always #10 clk = ~clk;

  adc_seq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  // converter: accepts one request, answers after a random delay
  always @(negedge clk) begin
    if (!rst_n) begin
      req_ready = 1'b0; rsp_valid = 1'b0; busy = 0;
    end else begin
      if (rsp_valid) begin rsp_valid = 1'b0; busy = 0; end
      else if (busy != 0) begin
        if (cnt == 0) begin
          if (rsp_ready) begin
            rsp_data = 10'((conv_n * 37 + 11) ^ (int'(cur_ch) << 6));
            data_log[ptr % 64] = rsp_data;
            ptr++; conv_n++;
            rsp_valid = 1'b1;
          end else busy = 0;
        end else cnt--;
      end
      if (busy == 0) begin
        req_ready = ($urandom % 4) != 0;
        if (req_valid && req_ready) begin
          busy = 1; cnt = $urandom % 4; cur_ch = req_chan;
          chan_log[nreq % 64] = req_chan; nreq++;
        end
      end else req_ready = 1'b0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #2 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_flag(output bit ok);
    logic [7:0] d;
    ok = 0;
    for (int i = 0; i < 400 && !ok; i++) begin
      rd(ADR_SEQ, d);
      ok = d[7];
    end
  endtask

  function automatic logic [15:0] fmt(input logic [9:0] r, input bit r8, input bit lj);
    if (r8) return lj ? {r[9:2], 8'h00} : {8'h00, r[9:2]};
    return lj ? {r, 6'h00} : {6'h00, r};
  endfunction

  task automatic run_seq(input logic [3:0] len, input logic [2:0] first, input bit multi,
                         input bit r8, input bit lj);
    bit ok;
    int n;
    logic [7:0] hi, lo, m;
    wr(ADR_PWR, 8'h80);
    wr(ADR_LEN, {4'h0, len});
    wr(ADR_FMT, {r8, 7'h00});
    nreq = 0; ptr = 0;
    wr(ADR_GO, {lj, 2'b00, multi, 1'b0, first});
    wait_flag(ok);
    check("R5 flag after sequence", 32'(ok), 32'd1);
    n = len[3] ? 8 : int'(len) + 1;
    check("R3 conversion count", nreq, n);
    for (int k = 0; k < n; k++) begin
      int ec = multi ? (int'(first) + k) % 8 : int'(first);
      check("R4 channel order", 32'(chan_log[k]), ec);
      rd(5'(16 + 2 * k), hi);
      rd(5'(17 + 2 * k), lo);
      check("R8 R4 result word", {16'h0, hi, lo}, {16'h0, fmt(data_log[k], r8, lj)});
    end
    rd(ADR_MAP, m);
    check("R9 slot bitmap", 32'(m), 32'(8'((9'h1 << n) - 1)));
  endtask

  initial begin
    logic [7:0] d;
    bit ok;
    int hits;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state and reserved space
    rd(ADR_SEQ, d);  check("R12 reset flag", 32'(d), 0);
    rd(ADR_MAP, d);  check("R12 reset bitmap", 32'(d), 0);
    rd(5'h10, d);    check("R12 reset result", 32'(d), 0);
    rd(ADR_PWR, d);  check("R12 reset enable", 32'(d), 0);
    check("R12 reset req_valid", 32'(req_valid), 0);
    rd(5'h00, d);    check("R12 reserved 0x00", 32'(d), 0);
    rd(5'h07, d);    check("R12 reserved 0x07", 32'(d), 0);
    rd(5'h0E, d);    check("R12 reserved 0x0E", 32'(d), 0);

    // R1 start while disabled does nothing
    wr(ADR_LEN, 8'h03);
    wr(ADR_GO, 8'h13);
    hits = 0;
    repeat (30) begin @(negedge clk); if (req_valid) hits++; end
    check("R1 no request while disabled", hits, 0);
    rd(ADR_SEQ, d); check("R1 no flag while disabled", 32'(d[7]), 0);

    // directed sequences
    run_seq(4'h0, 3'd3, 1'b1, 1'b1, 1'b0);
    run_seq(4'h9, 3'd5, 1'b1, 1'b0, 1'b0);   // R3 saturating length, wrap
    run_seq(4'h7, 3'd2, 1'b1, 1'b1, 1'b1);
    run_seq(4'h2, 3'd6, 1'b0, 1'b0, 1'b1);   // R4 single-channel repeat
    rd(ADR_LEN, d); check("R12 length readback", 32'(d), 32'h02);

    // R6 write-one clear
    wr(ADR_SEQ, 8'h00); rd(ADR_SEQ, d); check("R6 write 0 keeps flag", 32'(d[7]), 1);
    wr(ADR_SEQ, 8'h80); rd(ADR_SEQ, d); check("R6 write 1 clears flag", 32'(d[7]), 0);

    // R7 fast clear on result read
    run_seq(4'h1, 3'd0, 1'b1, 1'b1, 1'b0);
    rd(5'h10, d); rd(ADR_SEQ, d); check("R7 read without fast-clear", 32'(d[7]), 1);
    wr(ADR_PWR, 8'hC0);
    rd(5'h11, d); rd(ADR_SEQ, d); check("R7 read with fast-clear", 32'(d[7]), 0);

    // R6 / R9 start write clears flag and bitmap
    run_seq(4'h0, 3'd1, 1'b1, 1'b0, 1'b0);
    wr(ADR_LEN, 8'h07);
    nreq = 0; ptr = 0;
    wr(ADR_GO, 8'h10);
    rd(ADR_MAP, d); check("R9 bitmap cleared by start", 32'(d), 0);
    rd(ADR_SEQ, d); check("R6 start clears flag", 32'(d[7]), 0);
    wait_flag(ok);  check("R5 flag after restart", 32'(ok), 1);

    // R10 continuous mode
    wr(ADR_LEN, 8'h01);
    nreq = 0; ptr = 0;
    wr(ADR_GO, 8'h30);
    wait_flag(ok); check("R10 first pass flag", 32'(ok), 1);
    wr(ADR_SEQ, 8'h80);
    for (int i = 0; i < 400 && nreq < 6; i++) @(negedge clk);
    check("R10 keeps converting", 32'(nreq >= 6), 1);
    wait_flag(ok); check("R10 flag set again", 32'(ok), 1);
    wr(ADR_PWR, 8'h00);
    repeat (3) @(negedge clk);
    hits = 0;
    repeat (20) begin @(negedge clk); if (req_valid) hits++; end
    check("R1 disable stops stream", hits, 0);

    // R11 digital port
    wr(ADR_DEN, 8'hA5);
    pin_in = 8'h3C; rd(ADR_PORT, d); check("R11 port masked", 32'(d), 32'h24);
    pin_in = 8'hFF; rd(ADR_PORT, d); check("R11 port all high", 32'(d), 32'hA5);

    // randomized sequences
    for (int it = 0; it < 6; it++) begin
      run_seq(4'($urandom), 3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      wr(ADR_SEQ, 8'h80);
    end

    if (!done_rep) begin
      done_rep = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_rep) begin
      done_rep = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule